// File: doc/BRIEF.md
# Carrier-Detect Receive Gating Unit

This block sits in front of a synchronous serial receiver. It admits receive bits only while a carrier-detect input allows it. Everything runs on one system clock. The serial receive clock, receive data and carrier-detect arrive as inputs. The block detects each rising edge of the receive clock and samples the data bit at that edge. It passes the bit on when the carrier rules allow it. Each received frame is delimited by a start strobe on its first bit and an end strobe on its last bit. The end strobe carries a lost-carrier status flag, the flag a receive buffer descriptor would record for that frame.

Two mode inputs select the carrier handling. The sampling mode is either synchronous or immediate. In synchronous mode the carrier passes through a synchroniser and is examined only at receive-clock rising edges. In immediate mode the raw carrier level gates reception directly, and a carrier drop takes effect at once. The carrier mode is either envelope or pulse. In envelope mode the carrier must cover the whole frame, and losing it ends the frame with the lost flag set. In pulse mode the carrier only starts a frame, and a later drop is ignored. The frame length is a fixed number of bits set by a parameter.

Top module: `cd_rx_gate`

## Requirements
- R1: After reset, rx_en, bit_vld, sof, eof and lost are all 0.
- R2: While idle, no bit is accepted until the carrier is present at a receive-clock rising edge. The first accepted bit gives bit_vld=1 and sof=1, with bit_out equal to rx_data at that edge. rx_en is 1 from that bit until the frame ends.
- R3: After FRAME_BITS accepted bits, eof=1 is raised with the last bit and lost=0, and rx_en returns to 0 in the same cycle.
- R4: In envelope, synchronous mode (pulse_mode=0, imm_mode=0), a carrier that is low at a mid-frame rising edge ends the frame at that edge. The block raises eof=1 and lost=1 with no bit accepted, and no further bits are taken while the carrier stays low.
- R5: In synchronous mode, a carrier dip that recovers before the next receive-clock rising edge is not noticed: the frame completes with lost=0.
- R6: In envelope, immediate mode (pulse_mode=0, imm_mode=1), a mid-frame carrier drop gives eof=1 and lost=1 one system clock later, while the receive clock is still low and without waiting for a rising edge.
- R7: In immediate mode, a carrier raised one system clock before a rising edge admits the bit at that edge.
- R8: In synchronous mode, the carrier passes through a two-flop synchroniser. A carrier raised one system clock before a rising edge is not seen at that edge, and the first bit is taken at the following edge.
- R9: In pulse mode (pulse_mode=1), lost is never raised. A carrier drop has no effect on the frame in progress, which still delivers FRAME_BITS bits.
- R10: A carrier drop after the last bit of a frame raises no lost flag, and no new frame starts while the carrier remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_clk | input | 1 | Serial receive clock, sampled by clk |
| rx_data | input | 1 | Serial receive data, taken at rx_clk rising edges |
| cd_in | input | 1 | Carrier-detect, active high, asynchronous |
| imm_mode | input | 1 | 0 = synchronous carrier sampling, 1 = immediate |
| pulse_mode | input | 1 | 0 = envelope carrier, 1 = pulse carrier |
| rx_en | output | 1 | High while a frame is being received |
| bit_vld | output | 1 | One-cycle strobe: bit_out holds an accepted bit |
| bit_out | output | 1 | Accepted data bit |
| sof | output | 1 | Start-of-frame strobe, with the first bit |
| eof | output | 1 | End-of-frame strobe |
| lost | output | 1 | Lost-carrier status, valid with eof |

## Verification
The design registers a rising edge of the receive clock at the first system-clock edge where rx_clk reads high. Bits, sof and a normal eof appear one clock after that edge. A synchronous-mode carrier change needs two clocks to reach the gating logic. An immediate-mode drop shows as eof with lost one clock after the drop, while the receive clock is still low. The bench drives inputs on falling clock edges and keeps carrier changes inside the low phase of the receive clock. A monitor samples the outputs 2 ns after every rising edge, so each result is read in the cycle it is due. A sweep covers both sampling modes, both carrier modes and every drop position in the frame. For each case the bench computes the expected bit count, data, lost flag and receive-clock phase of the lost end arithmetically, and compares them with the tallied events.

// File: rtl/cdg_pkg.sv
package cdg_pkg;

    typedef enum logic {
        SAMPLE_SYNC = 1'b0,
        SAMPLE_IMM  = 1'b1
    } cd_sample_e;

    typedef enum logic {
        CARRIER_ENVELOPE = 1'b0,
        CARRIER_PULSE    = 1'b1
    } cd_carrier_e;

endpackage

// File: rtl/cdg_sync.sv
module cdg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_comb sh_d[i] = din;
            end else begin : g_next
                always_comb sh_d[i] = sh_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/cdg_edge.sv
module cdg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_clk,
    output logic rise
);
    logic rck_d, rck_q;

    always_comb rck_d = rx_clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rck_q <= 1'b0;
        else        rck_q <= rck_d;
    end

    assign rise = rx_clk & ~rck_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2

endmodule

// File: rtl/cdg_carrier.sv
module cdg_carrier
    import cdg_pkg::*;
(
    input  logic cd_raw,
    input  logic cd_sync,
    input  logic imm_mode,
    input  logic pulse_mode,
    input  logic rise,
    input  logic in_frame,
    output logic car_lvl,
    output logic loss
);
    cd_sample_e  smp_mode;
    cd_carrier_e car_mode;

    always_comb begin
        smp_mode = cd_sample_e'(imm_mode);
        car_mode = cd_carrier_e'(pulse_mode);
        car_lvl  = (smp_mode == SAMPLE_IMM) ? cd_raw : cd_sync;
        loss     = 1'b0;
        if (in_frame && car_mode == CARRIER_ENVELOPE && !car_lvl) begin
            loss = (smp_mode == SAMPLE_IMM) ? 1'b1 : rise;
        end
    end

endmodule

// File: rtl/cdg_framer.sv
module cdg_framer #(
    parameter int FRAME_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic rx_data,
    input  logic car_lvl,
    input  logic loss,
    output logic rx_en,
    output logic bit_vld,
    output logic bit_out,
    output logic sof,
    output logic eof,
    output logic lost
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic             in_frame;
        logic [CNT_W-1:0] cnt;
        logic             bit_vld;
        logic             bit_dat;
        logic             sof;
        logic             eof;
        logic             lost;
    } frm_st_t;

    frm_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.bit_vld = 1'b0;
        st_d.sof     = 1'b0;
        st_d.eof     = 1'b0;
        st_d.lost    = 1'b0;
        if (!st_q.in_frame) begin
            if (rise && car_lvl) begin
                st_d.bit_vld = 1'b1;
                st_d.bit_dat = rx_data;
                st_d.sof     = 1'b1;
                if (ONE == LAST) begin
                    st_d.eof = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.in_frame = 1'b1;
                    st_d.cnt      = ONE;
                end
            end
        end else if (loss) begin
            st_d.in_frame = 1'b0;
            st_d.cnt      = '0;
            st_d.eof      = 1'b1;
            st_d.lost     = 1'b1;
        end else if (rise) begin
            st_d.bit_vld = 1'b1;
            st_d.bit_dat = rx_data;
            if (st_q.cnt + ONE == LAST) begin
                st_d.eof      = 1'b1;
                st_d.in_frame = 1'b0;
                st_d.cnt      = '0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_en   = st_q.in_frame;
    assign bit_vld = st_q.bit_vld;
    assign bit_out = st_q.bit_dat;
    assign sof     = st_q.sof;
    assign eof     = st_q.eof;
    assign lost    = st_q.lost;

    AST_LOST_ONLY_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lost |-> (st_q.eof && !st_q.bit_vld)); // R4
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < LAST); // R3
    AST_EOF_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.eof |-> !st_q.in_frame); // R3
    AST_SOF_CARRIES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sof |-> st_q.bit_vld); // R2
    AST_NO_STRAY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bit_vld && !$past(st_q.in_frame)) |-> st_q.sof); // R2

endmodule

// File: rtl/cd_rx_gate.sv
module cd_rx_gate #(
    parameter int FRAME_BITS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_clk,
    input  logic rx_data,
    input  logic cd_in,
    input  logic imm_mode,
    input  logic pulse_mode,
    output logic rx_en,
    output logic bit_vld,
    output logic bit_out,
    output logic sof,
    output logic eof,
    output logic lost
);
    logic cd_sync;
    logic rise;
    logic car_lvl;
    logic loss;

    cdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cd_in),
        .dout (cd_sync)
    );

    cdg_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_clk(rx_clk),
        .rise  (rise)
    );

    cdg_carrier u_carrier (
        .cd_raw    (cd_in),
        .cd_sync   (cd_sync),
        .imm_mode  (imm_mode),
        .pulse_mode(pulse_mode),
        .rise      (rise),
        .in_frame  (rx_en),
        .car_lvl   (car_lvl),
        .loss      (loss)
    );

    cdg_framer #(.FRAME_BITS(FRAME_BITS)) u_framer (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (rise),
        .rx_data(rx_data),
        .car_lvl(car_lvl),
        .loss   (loss),
        .rx_en  (rx_en),
        .bit_vld(bit_vld),
        .bit_out(bit_out),
        .sof    (sof),
        .eof    (eof),
        .lost   (lost)
    );

    AST_IMM_CD_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_mode && rx_clk && $past(rx_clk)) |-> $stable(cd_in)); // R6
    AST_PULSE_NEVER_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> !$past(pulse_mode)); // R9
    AST_START_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> $past(car_lvl)); // R2

endmodule

// File: tb/cd_rx_gate_test.sv
`timescale 1ns/1ps
module cd_rx_gate_test;
    localparam int FB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_clk = 1'b0, rx_data = 1'b0, cd_in = 1'b0;
    logic imm_mode = 1'b0, pulse_mode = 1'b0;
    logic rx_en, bit_vld, bit_out, sof, eof, lost;

    cd_rx_gate #(.FRAME_BITS(FB), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_data(rx_data),
        .cd_in(cd_in), .imm_mode(imm_mode), .pulse_mode(pulse_mode),
        .rx_en(rx_en), .bit_vld(bit_vld), .bit_out(bit_out),
        .sof(sof), .eof(eof), .lost(lost)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int period_idx;
    logic mon_on = 1'b0;
    int n_bits, n_sof, n_eof, n_lost, en_bad, sof_period, first_bits;
    logic first_dat, first_lost, first_rxhi;
    logic [31:0] dat_acc;
    logic done = 1'b0;

    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            if (bit_vld) begin
                if (n_bits < 32) dat_acc[n_bits] = bit_out;
                n_bits++;
            end
            if (sof) begin
                n_sof++;
                if (n_sof == 1) begin
                    sof_period = period_idx;
                    first_dat  = bit_out;
                end
                if (!rx_en) en_bad++;
            end
            if (eof) begin
                n_eof++;
                if (rx_en) en_bad++;
                if (n_eof == 1) begin
                    first_bits = n_bits;
                    first_lost = lost;
                    first_rxhi = rx_clk;
                end
            end
            if (lost) n_lost++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_bits = 0; n_sof = 0; n_eof = 0; n_lost = 0; en_bad = 0;
        sof_period = -1; first_bits = -1; first_dat = 1'b0;
        first_lost = 1'b0; first_rxhi = 1'b0; dat_acc = '0;
        period_idx = -1;
        mon_on = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cd_in = 1'b0; rx_clk = 1'b0; rx_data = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One receive-clock period: 6 clocks low, then 4 clocks high.
    task automatic rx_period(input logic d, input logic cd_new, input int cd_at, input int dip);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (c == 0) begin
                rx_clk = 1'b0;
                rx_data = d;
                period_idx++;
            end
            if (c == cd_at) cd_in = cd_new;
            if (dip > 0 && c == 0) cd_in = 1'b0;
            if (dip > 0 && c == dip) cd_in = 1'b1;
        end
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (c == 0) rx_clk = 1'b1;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "rx_en", int'(rx_en), 0);
        chk("R1", "bit_vld", int'(bit_vld), 0);
        chk("R1", "sof", int'(sof), 0);
        chk("R1", "eof", int'(eof), 0);
        chk("R1", "lost", int'(lost), 0);

        // Sweep: sampling mode x carrier mode x drop position
        for (int im = 0; im < 2; im++) begin
            for (int env = 0; env < 2; env++) begin
                for (int k = 1; k <= FB; k++) begin
                    logic [31:0] pat;
                    logic [31:0] mask;
                    int exp_bits;
                    int exp_lost;
                    string tag;
                    pat = (32'hA5 ^ 32'(k * 37 + im * 3 + env * 5)) & 32'hFF;
                    imm_mode = im[0];
                    pulse_mode = ~env[0];
                    clear_mon();
                    rx_period(1'b1, 1'b0, 0, 0);
                    for (int p = 1; p <= 10; p++) begin
                        logic d;
                        d = pat[(p - 1) % 32];
                        if (p == 1)           rx_period(d, 1'b1, 0, 0);
                        else if (p == k + 1)  rx_period(d, 1'b0, 0, 0);
                        else                  rx_period(d, cd_in, -1, 0);
                    end
                    repeat (3) @(negedge clk);
                    exp_lost = (env == 1 && k < FB) ? 1 : 0;
                    exp_bits = (exp_lost == 1) ? k : FB;
                    if (env == 0)           tag = "R9";
                    else if (k == FB)       tag = "R10";
                    else if (im == 1)       tag = "R6";
                    else                    tag = "R4";
                    mask = (32'd1 << exp_bits) - 32'd1;
                    chk("R2", "sof count", n_sof, 1);
                    chk("R3", "eof count", n_eof, 1);
                    chk(tag, "bit count", n_bits, exp_bits);
                    chk(tag, "first eof lost", int'(first_lost), exp_lost);
                    chk(tag, "lost count", n_lost, exp_lost);
                    chk("R2", "data", int'(dat_acc & mask), int'(pat & mask));
                    chk("R2", "rx_en framing", en_bad, 0);
                    if (exp_lost == 1)
                        chk(tag, "rx_clk phase at lost eof", int'(first_rxhi), (im == 1) ? 0 : 1);
                    if (k == FB)
                        chk("R3", "bits at eof", first_bits, FB);
                    mon_on = 1'b0;
                end
            end
        end

        // Late carrier assertion: immediate R7, synchronous R8
        for (int im = 0; im < 2; im++) begin
            do_reset();
            imm_mode = im[0];
            pulse_mode = 1'b0;
            clear_mon();
            rx_period(1'b0, 1'b0, 0, 0);
            rx_period(1'b1, 1'b1, 5, 0);
            rx_period(1'b0, 1'b1, -1, 0);
            rx_period(1'b1, 1'b1, -1, 0);
            repeat (2) @(negedge clk);
            chk((im == 1) ? "R7" : "R8", "sof period", sof_period, (im == 1) ? 1 : 2);
            chk((im == 1) ? "R7" : "R8", "first bit", int'(first_dat), (im == 1) ? 1 : 0);
            mon_on = 1'b0;
        end

        // Carrier dip inside the low phase: synchronous R5, immediate R6
        for (int im = 0; im < 2; im++) begin
            do_reset();
            imm_mode = im[0];
            pulse_mode = 1'b0;
            clear_mon();
            rx_period(1'b0, 1'b0, 0, 0);
            rx_period(1'b1, 1'b1, 0, 0);
            for (int p = 2; p <= 9; p++)
                rx_period(p[0], 1'b1, -1, (p == 4) ? 2 : 0);
            repeat (2) @(negedge clk);
            chk((im == 1) ? "R6" : "R5", "first eof lost", int'(first_lost), im);
            chk((im == 1) ? "R6" : "R5", "bits at first eof", first_bits, (im == 1) ? 3 : FB);
            mon_on = 1'b0;
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule